// File: doc/BRIEF.md
# Cache Maintenance Command Queue Front End

This block sits between a processor register port and a cache maintenance engine. Software describes one maintenance command by writing a mode word, and then only those parameter registers that the chosen scope and target call for: a start address, a byte count, a way mask. The block decides when the description is complete. It then commits the command into a four-entry first-in first-out queue, and the engine drains that queue through a valid/ready descriptor port. The engine reports the end of each command with a single-cycle done pulse.

Each submission leaves a set-complete word. Its bits say whether the attempt was dropped because the queue was full, or whether an unfinished earlier submission was abandoned. In either case software repeats the whole sequence. A status word shows queue activity, an error summary and a sticky end flag. The end flag is raised when a command that asked for notification finishes and no work remains. A separate primitive register takes immediate drain requests (sync and prefetch-buffer flush). These are passed to the engine only once all queued work has gone. A read of the primitive register is not answered until the drain has been acknowledged.

Register offsets (word index on `addr_i`): 0 mode, 1 address, 2 size, 3 way mask, 4 set-complete, 5 status, 6 primitive.

Top module: `cmoq_frontend`

## Requirements
- R1: Mode word fields: bits 2:0 operation code (0 invalidate, 1 clean, 2 flush, 3 prefetch into cache, 4 prefetch into prefetch buffer, 5 touch, 6 touch to zero, 7 touch marked dirty), bit 14 auxiliary flag, bit 15 notify request, bits 18:17 scope (0 range, 1 whole cache, 2 by way), bits 22:21 target (0 data LRU, 1 instruction LRU, 2 way). A committed descriptor carries these fields unchanged on `cmd_op_o`, `cmd_aux_o`, `cmd_notify_o`, `cmd_scope_o` and `cmd_target_o`.
- R2: A mode write whose scope is not range, and whose scope is not by-way and target is not way, commits on that write. `cmd_valid_o` is high after the write's clock edge.
- R3: Range scope needs both the address and the size registers, in either order. The command commits on the write of the last one it needs and carries the written values.
- R4: By-way scope or way target needs the way-mask register. A command needing several parameters commits only when all of them have been written, and `cmd_ways_o` carries the mask.
- R5: A parameter write made when no command is waiting for parameters, or to a register the waiting command does not need, commits nothing.
- R6: The queue holds four commands and hands them out in commit order. `cmd_valid_o` and the descriptor are held while `cmd_ready_i` is low. A commit attempt while four commands are held drops the command and sets set-complete bit 1.
- R7: Every mode write clears both set-complete bits. A mode write arriving while an earlier command still waits for parameters abandons that command and sets set-complete bit 0.
- R8: Status bit 0 is 1 while the queue holds a command or the engine is working on one. Status bit 1 is the OR of the two set-complete bits. After reset, status, set-complete and `cmd_valid_o` are zero.
- R9: Status bit 2 (end flag) is set by a done pulse for a command that requested notification, when the queue is empty at that moment. A done pulse for a command without notification does not set it, and neither does one while commands remain queued. Writing status with bit 2 set clears the flag. If the clear and the setting done pulse fall in the same cycle, the flag ends set.
- R10: Writing 8 (sync) or 9 (prefetch-buffer flush) to the primitive register requests a drain. `drain_req_o` rises with `drain_code_o` equal to the code only once the queue is empty and the engine is idle, and it holds until `drain_done_i`. Any other code is ignored, and the register keeps its previous code.
- R11: A read is answered with `rvalid_o` one cycle after `rd_en_i`. A read of the primitive register waits while a drain is pending, and is answered in the cycle after `drain_done_i` with the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read response valid |
| cmd_valid_o | output | 1 | Queue head descriptor valid |
| cmd_ready_i | input | 1 | Engine takes the head descriptor |
| cmd_op_o | output | 3 | Operation code |
| cmd_scope_o | output | 2 | Scope |
| cmd_target_o | output | 2 | Target |
| cmd_notify_o | output | 1 | Notification requested |
| cmd_aux_o | output | 1 | Auxiliary flag |
| cmd_addr_o | output | 32 | Start address |
| cmd_size_o | output | 32 | Byte count |
| cmd_ways_o | output | 32 | Way mask |
| done_i | input | 1 | Engine finished the current command |
| drain_req_o | output | 1 | Immediate drain request |
| drain_code_o | output | 4 | Drain primitive code |
| drain_done_i | input | 1 | Engine finished the drain |

## Verification
Two events can land in one clock: the engine's done pulse for a notifying command, and software's write that clears the end flag. The bench sets the flag once, then starts a second notifying command. It drives the status clear write and the done pulse into the same clock, and reads status afterwards expecting the flag set, because the new completion must not be lost. A clear write with no completion beside it is then expected to leave the flag at zero.

// File: rtl/cmoq_pkg.sv
package cmoq_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    OFF_MODE = 3'd0,
    OFF_ADDR = 3'd1,
    OFF_SIZE = 3'd2,
    OFF_WAYS = 3'd3,
    OFF_SETC = 3'd4,
    OFF_STAT = 3'd5,
    OFF_PRIM = 3'd6
  } reg_off_e;

  localparam int OP_LSB     = 0;
  localparam int AUX_BIT    = 14;
  localparam int NOTIFY_BIT = 15;
  localparam int SCOPE_LSB  = 17;
  localparam int TGT_LSB    = 21;

  localparam logic [1:0] SCOPE_RANGE = 2'd0;
  localparam logic [1:0] SCOPE_WAY   = 2'd2;
  localparam logic [1:0] TGT_WAY     = 2'd2;

  localparam logic [3:0] PRIM_SYNC   = 4'd8;
  localparam logic [3:0] PRIM_PFBUF  = 4'd9;

  localparam int ST_BUSY = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_END  = 2;

  // parameter-need mask bit positions
  localparam int NEED_ADDR = 0;
  localparam int NEED_SIZE = 1;
  localparam int NEED_WAYS = 2;

  typedef struct packed {
    logic [2:0]       op;
    logic [1:0]       scope;
    logic [1:0]       target;
    logic             notify;
    logic             aux;
    logic [REG_W-1:0] addr;
    logic [REG_W-1:0] size;
    logic [REG_W-1:0] ways;
  } cmd_desc_t;
endpackage

// File: rtl/cmoq_fifo.sv
module cmoq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     entry_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             do_push, do_pop;

  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign empty_o = (count_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = entry_q[rd_ptr_q];
  assign count_o = count_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     entry_q[i] <= '0;
      else if (do_push && wr_ptr_q == PTR_W'(i))       entry_q[i] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end
endmodule

// File: rtl/cmoq_decode.sv
module cmoq_decode
  import cmoq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              q_full_i,
  output logic              commit_o,
  output logic              push_o,
  output cmd_desc_t         desc_o,
  output logic              fe_o,
  output logic              oe_o,
  output logic [REG_W-1:0]  mode_o,
  output logic [REG_W-1:0]  addr_o,
  output logic [REG_W-1:0]  size_o,
  output logic [REG_W-1:0]  ways_o
);
  logic             mode_wr;
  logic [2:0]       wr_bits, need_w, need_q, have_q;
  logic             armed_q, fe_q, oe_q;
  logic [REG_W-1:0] mode_q, addr_q, size_q, ways_q, mode_src;
  logic [1:0]       w_scope, w_tgt;

  assign mode_wr            = wr_en_i && (addr_i == OFF_MODE);
  assign wr_bits[NEED_ADDR] = wr_en_i && (addr_i == OFF_ADDR);
  assign wr_bits[NEED_SIZE] = wr_en_i && (addr_i == OFF_SIZE);
  assign wr_bits[NEED_WAYS] = wr_en_i && (addr_i == OFF_WAYS);

  assign w_scope = wdata_i[SCOPE_LSB +: 2];
  assign w_tgt   = wdata_i[TGT_LSB +: 2];
  assign need_w[NEED_ADDR] = (w_scope == SCOPE_RANGE);
  assign need_w[NEED_SIZE] = (w_scope == SCOPE_RANGE);
  assign need_w[NEED_WAYS] = (w_scope == SCOPE_WAY) || (w_tgt == TGT_WAY);

  // armed implies need not yet met, so a satisfying write is always the last one
  always_comb begin
    if (mode_wr) commit_o = (need_w == '0);
    else         commit_o = armed_q && (|wr_bits) &&
                            (((have_q | wr_bits) & need_q) == need_q);
  end
  assign push_o = commit_o && !q_full_i;

  assign mode_src      = mode_wr ? wdata_i : mode_q;
  assign desc_o.op     = mode_src[OP_LSB +: 3];
  assign desc_o.scope  = mode_src[SCOPE_LSB +: 2];
  assign desc_o.target = mode_src[TGT_LSB +: 2];
  assign desc_o.notify = mode_src[NOTIFY_BIT];
  assign desc_o.aux    = mode_src[AUX_BIT];
  assign desc_o.addr   = wr_bits[NEED_ADDR] ? wdata_i : addr_q;
  assign desc_o.size   = wr_bits[NEED_SIZE] ? wdata_i : size_q;
  assign desc_o.ways   = wr_bits[NEED_WAYS] ? wdata_i : ways_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      addr_q  <= '0;
      size_q  <= '0;
      ways_q  <= '0;
      need_q  <= '0;
      have_q  <= '0;
      armed_q <= 1'b0;
      fe_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      if (wr_bits[NEED_ADDR]) addr_q <= wdata_i;
      if (wr_bits[NEED_SIZE]) size_q <= wdata_i;
      if (wr_bits[NEED_WAYS]) ways_q <= wdata_i;
      if (mode_wr) begin
        mode_q  <= wdata_i;
        need_q  <= need_w;
        have_q  <= '0;
        armed_q <= (need_w != '0);
        oe_q    <= armed_q;
        fe_q    <= commit_o && q_full_i;
      end else begin
        have_q <= have_q | wr_bits;
        if (commit_o) begin
          armed_q <= 1'b0;
          fe_q    <= fe_q | q_full_i;
        end
      end
    end
  end

  assign fe_o   = fe_q;
  assign oe_o   = oe_q;
  assign mode_o = mode_q;
  assign addr_o = addr_q;
  assign size_o = size_q;
  assign ways_o = ways_q;
endmodule

// File: rtl/cmoq_status.sv
module cmoq_status
  import cmoq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pop_i,
  input  logic       head_notify_i,
  input  logic       done_i,
  input  logic       q_empty_i,
  input  logic       push_i,
  input  logic       clr_end_i,
  input  logic       prim_wr_i,
  input  logic [3:0] prim_code_i,
  input  logic       drain_done_i,
  output logic       eng_busy_o,
  output logic       end_o,
  output logic       drain_req_o,
  output logic       prim_pend_o,
  output logic [3:0] prim_code_o
);
  logic       busy_q, act_notify_q, end_q, pend_q;
  logic [3:0] code_q;
  logic       end_set, q_idle, code_ok;

  assign end_set = done_i && busy_q && act_notify_q && q_empty_i && !push_i;
  assign q_idle  = q_empty_i && !busy_q;
  assign code_ok = (prim_code_i == PRIM_SYNC) || (prim_code_i == PRIM_PFBUF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= 1'b0;
      act_notify_q <= 1'b0;
      end_q        <= 1'b0;
      pend_q       <= 1'b0;
      code_q       <= '0;
    end else begin
      if (pop_i) begin
        busy_q       <= 1'b1;
        act_notify_q <= head_notify_i;
      end else if (done_i) begin
        busy_q       <= 1'b0;
      end
      // a completion in the clearing cycle must survive
      if (end_set)        end_q <= 1'b1;
      else if (clr_end_i) end_q <= 1'b0;
      if (pend_q) begin
        if (drain_done_i && q_idle) pend_q <= 1'b0;
      end else if (prim_wr_i && code_ok) begin
        pend_q <= 1'b1;
        code_q <= prim_code_i;
      end
    end
  end

  assign eng_busy_o  = busy_q;
  assign end_o       = end_q;
  assign drain_req_o = pend_q && q_idle;
  assign prim_pend_o = pend_q;
  assign prim_code_o = code_q;
endmodule

// File: rtl/cmoq_frontend.sv
module cmoq_frontend
  import cmoq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              rvalid_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [2:0]        cmd_op_o,
  output logic [1:0]        cmd_scope_o,
  output logic [1:0]        cmd_target_o,
  output logic              cmd_notify_o,
  output logic              cmd_aux_o,
  output logic [REG_W-1:0]  cmd_addr_o,
  output logic [REG_W-1:0]  cmd_size_o,
  output logic [REG_W-1:0]  cmd_ways_o,
  input  logic              done_i,
  output logic              drain_req_o,
  output logic [3:0]        drain_code_o,
  input  logic              drain_done_i
);
  localparam int DESC_W = $bits(cmd_desc_t);

  cmd_desc_t        new_desc, head;
  logic [DESC_W-1:0] head_raw;
  logic             dec_commit, push, pop, q_full, q_empty;
  logic [CNT_W-1:0] q_count;
  logic             sef_fe, sef_oe, eng_busy, end_flag, prim_pend;
  logic [REG_W-1:0] mode_q, addr_q, size_q, ways_q;
  logic             rd_pend_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic             clr_end, prim_wr;

  cmoq_decode u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .q_full_i (q_full),
    .commit_o (dec_commit),
    .push_o   (push),
    .desc_o   (new_desc),
    .fe_o     (sef_fe),
    .oe_o     (sef_oe),
    .mode_o   (mode_q),
    .addr_o   (addr_q),
    .size_o   (size_q),
    .ways_o   (ways_q)
  );

  cmoq_fifo #(.W(DESC_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  (new_desc),
    .pop_i   (pop),
    .head_o  (head_raw),
    .count_o (q_count),
    .full_o  (q_full),
    .empty_o (q_empty)
  );

  assign head         = cmd_desc_t'(head_raw);
  assign cmd_valid_o  = !q_empty;
  assign pop          = cmd_valid_o && cmd_ready_i;
  assign cmd_op_o     = head.op;
  assign cmd_scope_o  = head.scope;
  assign cmd_target_o = head.target;
  assign cmd_notify_o = head.notify;
  assign cmd_aux_o    = head.aux;
  assign cmd_addr_o   = head.addr;
  assign cmd_size_o   = head.size;
  assign cmd_ways_o   = head.ways;

  assign clr_end = wr_en_i && (addr_i == OFF_STAT) && wdata_i[ST_END];
  assign prim_wr = wr_en_i && (addr_i == OFF_PRIM);

  cmoq_status u_stat (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pop_i         (pop),
    .head_notify_i (head.notify),
    .done_i        (done_i),
    .q_empty_i     (q_empty),
    .push_i        (push),
    .clr_end_i     (clr_end),
    .prim_wr_i     (prim_wr),
    .prim_code_i   (wdata_i[3:0]),
    .drain_done_i  (drain_done_i),
    .eng_busy_o    (eng_busy),
    .end_o         (end_flag),
    .drain_req_o   (drain_req_o),
    .prim_pend_o   (prim_pend),
    .prim_code_o   (drain_code_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q <= 1'b0;
      rd_addr_q <= '0;
    end else if (rvalid_o) begin
      rd_pend_q <= 1'b0;
    end else if (rd_en_i && !rd_pend_q) begin
      rd_pend_q <= 1'b1;
      rd_addr_q <= addr_i;
    end
  end

  assign rvalid_o = rd_pend_q && !((rd_addr_q == OFF_PRIM) && prim_pend);

  always_comb begin
    rdata_o = '0;
    case (rd_addr_q)
      OFF_MODE: rdata_o = mode_q;
      OFF_ADDR: rdata_o = addr_q;
      OFF_SIZE: rdata_o = size_q;
      OFF_WAYS: rdata_o = ways_q;
      OFF_SETC: rdata_o = {{(REG_W-2){1'b0}}, sef_fe, sef_oe};
      OFF_STAT: rdata_o = {{(REG_W-3){1'b0}}, end_flag, sef_fe | sef_oe,
                           !q_empty || eng_busy};
      OFF_PRIM: rdata_o = {{(REG_W-4){1'b0}}, drain_code_o};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cmoq_frontend_chk.sv
module cmoq_frontend_chk
  import cmoq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [REG_W-1:0]  wdata_i,
  input logic              cmd_valid_o,
  input logic              cmd_ready_i,
  input logic [2:0]        cmd_op_o,
  input logic [REG_W-1:0]  cmd_addr_o,
  input logic              done_i,
  input logic              drain_req_o,
  input logic              rvalid_o,
  input logic              dec_commit,
  input logic              q_full,
  input logic [CNT_W-1:0]  q_count,
  input logic              sef_fe,
  input logic              eng_busy,
  input logic              end_flag,
  input logic              prim_pend,
  input logic [ADDR_W-1:0] rd_addr_q
);
  assert_head_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_addr_o));

  assert_drop_when_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_commit && q_full && !cmd_ready_i |=> sef_fe && q_count == CNT_W'(DEPTH));

  assert_count_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_count <= CNT_W'(DEPTH));

  assert_drain_only_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_req_o |-> !cmd_valid_o && !eng_busy);

  assert_end_rise_on_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(end_flag) |-> $past(done_i));

  assert_end_fall_on_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(end_flag) |-> $past(wr_en_i && addr_i == OFF_STAT && wdata_i[ST_END]));

  assert_prim_read_wait_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && rd_addr_q == OFF_PRIM |-> !prim_pend);
endmodule

bind cmoq_frontend cmoq_frontend_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .cmd_valid_o (cmd_valid_o),
  .cmd_ready_i (cmd_ready_i),
  .cmd_op_o    (cmd_op_o),
  .cmd_addr_o  (cmd_addr_o),
  .done_i      (done_i),
  .drain_req_o (drain_req_o),
  .rvalid_o    (rvalid_o),
  .dec_commit  (dec_commit),
  .q_full      (q_full),
  .q_count     (q_count),
  .sef_fe      (sef_fe),
  .eng_busy    (eng_busy),
  .end_flag    (end_flag),
  .prim_pend   (prim_pend),
  .rd_addr_q   (rd_addr_q)
);

// File: tb/cmoq_frontend_bench.sv
module cmoq_frontend_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        cmd_valid, cmd_ready = 1'b0;
  logic [2:0]  cmd_op;
  logic [1:0]  cmd_scope, cmd_target;
  logic        cmd_notify, cmd_aux;
  logic [31:0] cmd_addr, cmd_size, cmd_ways;
  logic        done = 1'b0;
  logic        drain_req;
  logic [3:0]  drain_code;
  logic        drain_done = 1'b0;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  cmoq_frontend u_cmoq_frontend (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_op_o(cmd_op),
    .cmd_scope_o(cmd_scope), .cmd_target_o(cmd_target),
    .cmd_notify_o(cmd_notify), .cmd_aux_o(cmd_aux), .cmd_addr_o(cmd_addr),
    .cmd_size_o(cmd_size), .cmd_ways_o(cmd_ways), .done_i(done),
    .drain_req_o(drain_req), .drain_code_o(drain_code),
    .drain_done_i(drain_done)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 60000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: act=%0d exp=<60000 cycles", cyc);
      summary();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d, output int lat);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; lat = 1;
    while (!rvalid && lat < 40) begin @(negedge clk); lat++; end
    d = rdata;
  endtask

  task automatic pop();
    @(negedge clk); cmd_ready = 1'b1;
    @(negedge clk); cmd_ready = 1'b0;
  endtask

  task automatic fin();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  function automatic logic [31:0] mk_mode(int op, int s, int t, bit nt, bit ax);
    return 32'(op & 7) | (32'(nt) << 15) | (32'(ax) << 14) |
           (32'(s & 3) << 17) | (32'(t & 3) << 21);
  endfunction

  initial begin
    logic [31:0] d;
    int lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset valid", 32'(cmd_valid), 0);
    rd(3'd5, d, lat); chk("R8 reset status", d, 0);
    chk("R11 read latency", 32'(lat), 1);
    rd(3'd4, d, lat); chk("R8 reset setc", d, 0);
    chk("R10 reset drain", 32'(drain_req), 0);

    wr(3'd1, 32'h55); wr(3'd3, 32'h3);
    chk("R5 stray param", 32'(cmd_valid), 0);

    // sweep scope x target, with rotating parameter order
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < 4; t++) begin
        int op; bit nt, ax, na, nw, ha, hs, hw, com;
        logic [31:0] av, sv, wv;
        int ord [3];
        string tag;
        op = (s * 4 + t) % 8; nt = bit'((s + t) % 2); ax = bit'(s % 2);
        av = 32'h1000_0000 + 32'(s * 256 + t * 16);
        sv = 32'h80 * 32'(s + t + 1);
        wv = 32'h1 << t;
        case ((s * 4 + t) % 6)
          0: ord = '{1, 2, 3};
          1: ord = '{1, 3, 2};
          2: ord = '{2, 1, 3};
          3: ord = '{2, 3, 1};
          4: ord = '{3, 1, 2};
          default: ord = '{3, 2, 1};
        endcase
        na = (s == 0); nw = (s == 2) || (t == 2);
        tag = na ? "R3" : (nw ? "R4" : "R5");
        ha = 0; hs = 0; hw = 0;
        wr(3'd5, 32'h4);
        wr(3'd0, mk_mode(op, s, t, nt, ax));
        com = !na && !nw;
        chk(com ? "R2 commit on mode" : "R3 R4 wait params", 32'(cmd_valid), 32'(com));
        rd(3'd4, d, lat); chk("R7 setc clear", d, 0);
        for (int k = 0; k < 3; k++) begin
          case (ord[k])
            1: begin wr(3'd1, av); ha = 1; end
            2: begin wr(3'd2, sv); hs = 1; end
            default: begin wr(3'd3, wv); hw = 1; end
          endcase
          com = (!na || (ha && hs)) && (!nw || hw);
          chk({tag, " commit point"}, 32'(cmd_valid), 32'(com));
        end
        chk("R1 op", 32'(cmd_op), 32'(op));
        chk("R1 scope", 32'(cmd_scope), 32'(s));
        chk("R1 target", 32'(cmd_target), 32'(t));
        chk("R1 notify", 32'(cmd_notify), 32'(nt));
        chk("R1 aux", 32'(cmd_aux), 32'(ax));
        if (na) begin
          chk("R3 addr", cmd_addr, av);
          chk("R3 size", cmd_size, sv);
        end
        if (nw) chk("R4 ways", cmd_ways, wv);
        pop();
        chk("R5 no duplicate", 32'(cmd_valid), 0);
        rd(3'd5, d, lat); chk("R8 busy", d, 32'h1);
        fin();
        rd(3'd5, d, lat); chk("R9 end after done", d, 32'(nt) << 2);
      end
    end
    wr(3'd5, 32'h4);

    // queue depth and drop on full
    for (int i = 0; i < 5; i++) begin
      wr(3'd0, mk_mode(i, 1, 0, 0, 0));
      rd(3'd4, d, lat);
      chk("R6 setc full", d, (i == 4) ? 32'h2 : 32'h0);
    end
    rd(3'd5, d, lat); chk("R8 err and busy", d, 32'h3);
    for (int i = 0; i < 4; i++) begin
      chk("R6 valid", 32'(cmd_valid), 1);
      chk("R6 order", 32'(cmd_op), 32'(i));
      pop(); fin();
    end
    chk("R6 dropped fifth", 32'(cmd_valid), 0);

    // abandoned submission
    wr(3'd0, mk_mode(1, 0, 0, 0, 0));
    wr(3'd0, mk_mode(5, 1, 0, 0, 0));
    rd(3'd4, d, lat); chk("R7 abandon", d, 32'h1);
    chk("R7 second commits", 32'(cmd_op), 5);
    pop(); fin();
    wr(3'd0, mk_mode(6, 1, 1, 0, 0));
    rd(3'd4, d, lat); chk("R7 clean resubmit", d, 0);
    pop(); fin();

    // end flag waits for empty queue
    wr(3'd0, mk_mode(2, 1, 0, 1, 0));
    wr(3'd0, mk_mode(2, 1, 0, 1, 0));
    pop(); fin();
    rd(3'd5, d, lat); chk("R9 queue not empty", d & 32'h4, 0);
    pop(); fin();
    rd(3'd5, d, lat); chk("R9 queue empty", d & 32'h4, 32'h4);

    // clear and setting done in the same cycle
    wr(3'd0, mk_mode(0, 1, 0, 1, 0));
    pop();
    @(negedge clk); wr_en = 1'b1; addr = 3'd5; wdata = 32'h4; done = 1'b1;
    @(negedge clk); wr_en = 1'b0; done = 1'b0;
    rd(3'd5, d, lat); chk("R9 set wins", d & 32'h4, 32'h4);
    wr(3'd5, 32'h4);
    rd(3'd5, d, lat); chk("R9 clear", d & 32'h4, 0);

    // drain primitive
    wr(3'd0, mk_mode(1, 1, 0, 0, 0));
    wr(3'd6, 32'h8);
    chk("R10 held by queue", 32'(drain_req), 0);
    pop();
    chk("R10 held by engine", 32'(drain_req), 0);
    fin();
    chk("R10 drain req", 32'(drain_req), 1);
    chk("R10 drain code", 32'(drain_code), 8);
    @(negedge clk); rd_en = 1'b1; addr = 3'd6;
    @(negedge clk); rd_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 read waits", 32'(rvalid), 0);
    drain_done = 1'b1;
    @(negedge clk); drain_done = 1'b0;
    chk("R11 read released", 32'(rvalid), 1);
    chk("R11 read code", rdata, 32'h8);
    chk("R10 req dropped", 32'(drain_req), 0);
    wr(3'd6, 32'h5);
    chk("R10 bad code ignored", 32'(drain_req), 0);
    rd(3'd6, d, lat); chk("R10 code kept", d, 32'h8);
    chk("R11 idle prim latency", 32'(lat), 1);
    wr(3'd6, 32'h9);
    chk("R10 flush req", 32'(drain_req), 1);
    chk("R10 flush code", 32'(drain_code), 9);
    @(negedge clk); drain_done = 1'b1;
    @(negedge clk); drain_done = 1'b0;
    chk("R10 flush done", 32'(drain_req), 0);

    summary();
  end
endmodule